// File: doc/BRIEF.md
# Flash Erase-Block Write-Lock Manager

This block holds a write-lock state for every erase block of a flash array and carries out the commands that change those states. Each block is in exactly one of three states: open for writing, locked, or permanently sealed. The sealed state is sticky. The open and lock commands cannot override a sealed block, and only a cold reset clears it. A cold reset puts every block into the locked state.

Software first writes a first-block and a last-block register, then issues a command opcode. The block walks the selected range one erase block per clock. While it walks, `busy` is high. When the walk ends, a single-cycle `done` pulse follows. An index past the populated block count also raises `err` on that pulse. The status word always shows the state most recently written into any block.

Checking program and erase requests against the lock table is left to the surrounding logic.

Top module: `blk_wlock_mgr`

## Requirements
- R1: After a cold reset (`rst` high), `busy`, `done` and `err` are low, `wp_status` reads 0x0002, and every block is locked. The states are one-hot coded: bit 0 set means sealed, bit 1 set means locked, bit 2 set means open.
- R2: A write to the first-block register (`start_wr`) stores `wr_data` masked to 2^BLK_AW-1 into both the first-block and last-block registers. A write to the last-block register (`end_wr`) changes only the last-block register.
- R3: Opcode 0x23 opens the blocks from first to last, in ascending order. If the walk reaches a sealed block, it ends there without error, and that block and every later block stay unchanged.
- R4: Opcode 0x2A locks the blocks from first to last, in ascending order. It ends without error at the first sealed block, in the same way as R3.
- R5: Opcode 0x27 ignores both range registers. It opens blocks from index 0 up to NUM_BLK-1 and ends without error at the first sealed block.
- R6: Opcode 0x2C seals every block from first to last that is not open. Open blocks are passed over and the walk goes on to the next index. An already sealed block is written again.
- R7: During 0x23, 0x2A or 0x2C, reaching an index at or above NUM_BLK ends the walk. `err` and `done` are then high together for one cycle. Blocks visited before that index keep their new states.
- R8: Each visited index takes exactly one cycle of `busy`. `done` is high for exactly one cycle, the one right after the last step. If the first block is greater than the last block, a range command raises `done` in the cycle after the strobe, with no `busy` cycle and no state change.
- R9: A command strobe while `busy` is high is ignored. A strobe with any opcode other than 0x23, 0x27, 0x2A or 0x2C is also ignored: no `busy`, no `done`, and no state change.
- R10: `wp_status` holds the zero-extended 3-bit state last written into a block. A block that is passed over, or a walk that ends at a sealed block, leaves `wp_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| start_wr | input | 1 | Write strobe for the first-block register |
| end_wr | input | 1 | Write strobe for the last-block register |
| wr_data | input | DATA_W | Data for a register write |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| err | output | 1 | One-cycle pulse at an out-of-range index |
| wp_status | output | WP_W | State most recently written into a block |

## Verification
The bench builds the block with BLK_AW=4 and NUM_BLK=12. The range registers therefore address 16 indices while only 12 blocks are populated, so indices 12 to 15 reach the error path of R7.

A full sweep of the block takes only 12 cycles. The bench counts the `busy` cycles of every command and checks that count against its own model of the lock table. Since each visited index costs one cycle, the count shows exactly where a walk stopped early at a sealed block or at an out-of-range index.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

  typedef logic [2:0] lk_state_t;
  localparam lk_state_t LK_SEALED = 3'b001;
  localparam lk_state_t LK_LOCKED = 3'b010;
  localparam lk_state_t LK_OPEN   = 3'b100;

  localparam logic [7:0] OPC_OPEN_RANGE = 8'h23;
  localparam logic [7:0] OPC_OPEN_ALL   = 8'h27;
  localparam logic [7:0] OPC_LOCK_RANGE = 8'h2A;
  localparam logic [7:0] OPC_SEAL_RANGE = 8'h2C;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'd0,
    MODE_LOCK  = 2'd1,
    MODE_SEAL  = 2'd2,
    MODE_ALL   = 2'd3
  } walk_mode_t;

  typedef enum logic [1:0] {
    ACT_WRITE = 2'd0,
    ACT_SKIP  = 2'd1,
    ACT_HALT  = 2'd2
  } step_act_t;

endpackage

// File: rtl/wlock_range_regs.sv
module wlock_range_regs #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          end_wr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] last_o
);

  logic [AW-1:0] first_q, last_q;
  logic          unused_hi;

  // The low AW bits are the block index; everything above is dropped.
  assign unused_hi = ^wr_data[DW-1:AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (start_wr) begin
      first_q <= wr_data[AW-1:0];
      last_q  <= wr_data[AW-1:0];
    end else if (end_wr) begin
      last_q  <= wr_data[AW-1:0];
    end
  end

  assign first_o = first_q;
  assign last_o  = last_q;

endmodule

// File: rtl/wlock_state_array.sv
module wlock_state_array
  import wlock_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_idx,
  output lk_state_t     rd_state,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  lk_state_t     wr_state
);

  localparam int DEPTH = 2 ** AW;

  lk_state_t rd_view [DEPTH];

  // One register per entry, so that a cold reset can set every entry at once.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    lk_state_t cell_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= LK_LOCKED;
      end else if (we && (wr_idx == AW'(g))) begin
        cell_q <= wr_state;
      end
    end
    assign rd_view[g] = cell_q;
  end

  assign rd_state = rd_view[rd_idx];

endmodule

// File: rtl/wlock_step_policy.sv
module wlock_step_policy
  import wlock_pkg::*;
(
  input  walk_mode_t mode_i,
  input  lk_state_t  cur_i,
  output step_act_t  act_o,
  output lk_state_t  new_o
);

  always_comb begin
    act_o = ACT_WRITE;
    new_o = LK_OPEN;
    unique case (mode_i)
      MODE_OPEN, MODE_ALL: begin
        new_o = LK_OPEN;
        act_o = (cur_i == LK_SEALED) ? ACT_HALT : ACT_WRITE;
      end
      MODE_LOCK: begin
        new_o = LK_LOCKED;
        act_o = (cur_i == LK_SEALED) ? ACT_HALT : ACT_WRITE;
      end
      MODE_SEAL: begin
        new_o = LK_SEALED;
        act_o = (cur_i == LK_OPEN) ? ACT_SKIP : ACT_WRITE;
      end
      default: begin
        act_o = ACT_HALT;
      end
    endcase
  end

endmodule

// File: rtl/wlock_walker.sv
module wlock_walker
  import wlock_pkg::*;
#(
  parameter int AW      = 4,
  parameter int NUM_BLK = 12,
  parameter int WP_W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_op,
  input  logic [AW-1:0]   first_i,
  input  logic [AW-1:0]   last_i,
  input  step_act_t       act_i,
  input  lk_state_t       new_state_i,
  output walk_mode_t      mode_o,
  output logic [AW-1:0]   idx_o,
  output logic            wr_en_o,
  output lk_state_t       wr_state_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [WP_W-1:0] wp_o
);

  localparam logic [AW:0]   LIMIT    = (AW + 1)'(NUM_BLK);
  localparam logic [AW-1:0] LAST_ALL = AW'(NUM_BLK - 1);

  logic            busy_q, done_q, err_q;
  logic [AW-1:0]   idx_q, end_q;
  walk_mode_t      mode_q;
  logic [WP_W-1:0] wp_q;

  logic            known;
  walk_mode_t      dmode;
  logic            oor;

  always_comb begin
    known = 1'b1;
    dmode = MODE_OPEN;
    case (cmd_op)
      OPC_OPEN_RANGE: dmode = MODE_OPEN;
      OPC_OPEN_ALL:   dmode = MODE_ALL;
      OPC_LOCK_RANGE: dmode = MODE_LOCK;
      OPC_SEAL_RANGE: dmode = MODE_SEAL;
      default:        known = 1'b0;
    endcase
  end

  assign oor     = ({1'b0, idx_q} >= LIMIT);
  assign wr_en_o = busy_q && !oor && (act_i == ACT_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
      mode_q <= MODE_OPEN;
      wp_q   <= WP_W'(LK_LOCKED);
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        if (oor) begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (act_i == ACT_HALT || idx_q == end_q) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        if (wr_en_o) begin
          wp_q <= WP_W'(new_state_i);
        end
      end else if (cmd_valid && known) begin
        mode_q <= dmode;
        if (dmode == MODE_ALL) begin
          idx_q  <= '0;
          end_q  <= LAST_ALL;
          busy_q <= 1'b1;
        end else if (first_i > last_i) begin
          done_q <= 1'b1;
        end else begin
          idx_q  <= first_i;
          end_q  <= last_i;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign mode_o     = mode_q;
  assign idx_o      = idx_q;
  assign wr_state_o = new_state_i;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign wp_o       = wp_q;

endmodule

// File: rtl/blk_wlock_mgr.sv
module blk_wlock_mgr
  import wlock_pkg::*;
#(
  parameter int BLK_AW  = 4,
  parameter int NUM_BLK = 12,
  parameter int DATA_W  = 16,
  parameter int WP_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              end_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WP_W-1:0]   wp_status
);

  logic [BLK_AW-1:0] first_idx, last_idx, walk_idx;
  lk_state_t         cur_state, next_state, wr_state;
  step_act_t         step_act;
  walk_mode_t        walk_mode;
  logic              wr_en;

  wlock_range_regs #(.AW(BLK_AW), .DW(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .start_wr (start_wr),
    .end_wr   (end_wr),
    .wr_data  (wr_data),
    .first_o  (first_idx),
    .last_o   (last_idx)
  );

  wlock_state_array #(.AW(BLK_AW)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (walk_idx),
    .rd_state (cur_state),
    .we       (wr_en),
    .wr_idx   (walk_idx),
    .wr_state (wr_state)
  );

  wlock_step_policy u_policy (
    .mode_i (walk_mode),
    .cur_i  (cur_state),
    .act_o  (step_act),
    .new_o  (next_state)
  );

  wlock_walker #(.AW(BLK_AW), .NUM_BLK(NUM_BLK), .WP_W(WP_W)) u_walker (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .first_i     (first_idx),
    .last_i      (last_idx),
    .act_i       (step_act),
    .new_state_i (next_state),
    .mode_o      (walk_mode),
    .idx_o       (walk_idx),
    .wr_en_o     (wr_en),
    .wr_state_o  (wr_state),
    .busy_o      (busy),
    .done_o      (done),
    .err_o       (err),
    .wp_o        (wp_status)
  );

endmodule

// File: rtl/blk_wlock_mgr_chk.sv
module blk_wlock_mgr_chk #(
  parameter int WP_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [WP_W-1:0] wp_status
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !err && wp_status == WP_W'(2)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  assert_wp_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(wp_status[2:0]) == 1) && (wp_status[WP_W-1:3] == '0));

endmodule

bind blk_wlock_mgr blk_wlock_mgr_chk #(.WP_W(WP_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .wp_status (wp_status)
);

// File: tb/blk_wlock_mgr_tb_top.sv
module blk_wlock_mgr_tb_top;

  localparam int AW = 4;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_wr = 1'b0, end_wr = 1'b0, cmd_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  cmd_op = '0;
  logic        busy, done, err;
  logic [15:0] wp_status;

  blk_wlock_mgr #(.BLK_AW(AW), .NUM_BLK(NB), .DATA_W(16), .WP_W(16)) dut_i (
    .clk(clk), .rst(rst), .start_wr(start_wr), .end_wr(end_wr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .err(err), .wp_status(wp_status)
  );

  always #5 clk = ~clk;

  int passed = 0;
  int total = 0;
  logic [2:0]  mdl [NB];
  int          es, ee;
  logic [15:0] ewp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: got %0d expected %0d", tag, act, exp);
  endtask

  task automatic wr_first(input int v);
    @(negedge clk); start_wr = 1'b1; wr_data = 16'(v);
    @(negedge clk); start_wr = 1'b0;
    es = v & ((1 << AW) - 1); ee = es;
  endtask

  task automatic wr_last(input int v);
    @(negedge clk); end_wr = 1'b1; wr_data = 16'(v);
    @(negedge clk); end_wr = 1'b0;
    ee = v & ((1 << AW) - 1);
  endtask

  // Reference model: open 3'b100, locked 3'b010, sealed 3'b001.
  task automatic model(input int op, output int vis, output bit xerr, output bit xdone);
    int lo, hi;
    vis = 0; xerr = 1'b0; xdone = 1'b1;
    if (op == 'h27) begin lo = 0; hi = NB - 1; end
    else if (op == 'h23 || op == 'h2A || op == 'h2C) begin lo = es; hi = ee; end
    else begin xdone = 1'b0; return; end
    for (int i = lo; i <= hi; i++) begin
      vis++;
      if (i >= NB) begin xerr = 1'b1; break; end
      if (op == 'h2C) begin
        if (mdl[i] == 3'b100) continue;
        mdl[i] = 3'b001; ewp = 16'h0001;
      end else begin
        if (mdl[i] == 3'b001) break;
        mdl[i] = (op == 'h2A) ? 3'b010 : 3'b100;
        ewp = {13'b0, mdl[i]};
      end
    end
  endtask

  task automatic do_cmd(input int op, input int inj, input string tag);
    int  xvis, vis;
    bit  xerr, xdone;
    model(op, xvis, xerr, xdone);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'(op);
    @(negedge clk); cmd_valid = 1'b0;
    vis = 0;
    while (busy && vis < 64) begin
      if (vis == inj) begin cmd_valid = 1'b1; cmd_op = 8'h2C; end
      else cmd_valid = 1'b0;
      vis++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(vis == xvis, {tag, " busy cycles R8"}, vis, xvis);
    chk(done == xdone, {tag, " done R8"}, int'(done), int'(xdone));
    chk(err == xerr, {tag, " err R7"}, int'(err), int'(xerr));
    chk(wp_status == ewp, {tag, " wp_status R10"}, int'(wp_status), int'(ewp));
    @(negedge clk);
    chk(done == 1'b0, {tag, " done single cycle R8"}, int'(done), 0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NB; i++) mdl[i] = 3'b010;
    ewp = 16'h0002; es = 0; ee = 0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0 && err == 1'b0, "R1 done/err", int'({done, err}), 0);
    chk(wp_status == 16'h0002, "R1 wp_status", int'(wp_status), 2);
  endtask

  task automatic t_regs();
    wr_first('h35);                  // masked to 5, last also 5
    do_cmd('h23, -1, "R2 first write copies to last");
    wr_last('h17);                   // last 7, first stays 5
    do_cmd('h2A, -1, "R2 last write only");
  endtask

  task automatic t_open();
    wr_first(2); wr_last(9);
    do_cmd('h23, -1, "R3 open range");
  endtask

  task automatic t_seal();
    wr_first(0); wr_last(11);
    do_cmd('h2C, -1, "R6 seal skips open blocks");
    wr_first(1);
    do_cmd('h2C, -1, "R6 reseal sealed block");
  endtask

  task automatic t_stops();
    wr_first(4);
    do_cmd('h2A, -1, "R4 lock single");
    wr_first(0); wr_last(3);
    do_cmd('h23, -1, "R3 stop at sealed");
    wr_first(2); wr_last(11);
    do_cmd('h2A, -1, "R4 lock stops at sealed");
  endtask

  task automatic t_range_err();
    wr_first('h1F);
    do_cmd('h2A, -1, "R7 first index out of range");
    wr_first(8); wr_last(15);
    do_cmd('h23, -1, "R7 walk into out of range");
    wr_first(13); wr_last(14);
    do_cmd('h2C, -1, "R7 seal out of range");
  endtask

  task automatic t_all();
    do_cmd('h27, -1, "R5 open all full sweep");
    wr_first(6);
    do_cmd('h2C, -1, "R6 seal on open block skipped");
    do_cmd('h2A, -1, "R4 relock block 6");
    do_cmd('h2C, -1, "R6 seal block 6");
    do_cmd('h27, -1, "R5 open all stops at sealed");
  endtask

  task automatic t_empty();
    wr_first(9); wr_last(3);
    do_cmd('h2A, -1, "R8 empty range");
  endtask

  task automatic t_ignore();
    wr_first(0); wr_last(5);
    do_cmd('h23, 2, "R9 strobe while busy");
    do_cmd('h2C, -1, "R9 range still open after busy strobe");
    do_cmd('h55, -1, "R9 unknown opcode");
    do_cmd('h27, -1, "R9 state after unknown opcode");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_open();
    t_seal();
    t_stops();
    t_reset();
    t_range_err();
    t_all();
    t_reset();
    t_empty();
    t_ignore();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule